// File: doc/BRIEF.md
# Acquisition Status and Interrupt Flag Register

This block keeps the eight-bit status word of a data-acquisition front end. It collects sticky event flags from the sample FIFO, the post-trigger countdown counter, the pacer counter chain and the DMA engine. It also reflects two live FIFO level bits and holds the convert-enable bit that gates all conversions. The FIFO and the counters sit outside the block. Only their status and terminal-count pulses come in.

The host sets convert-enable directly. It clears any event flag by writing a zero to that flag's bit, and writing a one leaves the flag as it is. A FIFO overflow switches convert-enable off and raises a one-cycle stop request toward the converter sequencer. A three-bit level code selects the interrupt line, or turns interrupts off. The code also decides whether an enabled event sets the interrupt flag. Each time the flag goes from 0 to 1, the block sends a fixed-width pulse on the selected line, so several sources can share that line.

Top module: `acq_status_reg`

## Requirements
- R1: After reset every status bit, every interrupt line and the stop request read 0.
- R2: Status bit 6 always equals the FIFO not-empty input and bit 5 the FIFO half-full input; host writes never change them.
- R3: An overflow event while the FIFO is enabled sets bit 4, clears bit 7 and drives stop_conv high for exactly one cycle, all visible one clock after the event.
- R4: Each event flag is gated by its own enable: overflow (bit 4) by fifo_enable, countdown terminal count (bit 3) by about_trig_en, pacer terminal count (bit 2) by pacer_irq_en, DMA terminal count (bit 1) by dma_en.
- R5: A host write with a 0 in any of bits 4..0 clears that flag on the next clock; a 1 in those positions leaves the flag unchanged.
- R6: When a flag's set event and a host clear of that flag occur in the same cycle, the flag ends up set.
- R7: A host write loads bit 7 (convert enable) from write-data bit 7, unless an overflow occurs in the same cycle.
- R8: With interrupts on and dma_en low, fifo_irq_mode 0 makes a rising FIFO not-empty input set bit 0, and fifo_irq_mode 1 makes a rising half-full input set it; the unselected FIFO input has no effect on bit 0.
- R9: With dma_en high, rising FIFO not-empty or half-full inputs never set bit 0, while an enabled DMA terminal count does.
- R10: Bit 0 is set by any enabled event only when the level code is not 000 or 100; with those two codes, flags still record but bit 0 stays 0 and no pulse appears.
- R11: The level code selects one irq_lines bit: 001 bit 0, 010 bit 1, 011 bit 2, 101 bit 3, 110 bit 4, 111 bit 5; at most one line is ever high.
- R12: Each 0-to-1 transition of bit 0 produces one pulse, PULSE_W clocks wide, starting two clocks after the triggering event. A further event while bit 0 stays set produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the status word |
| wr_data | input | 8 | Host write data |
| fifo_enable | input | 1 | FIFO is running (gates overflow flag) |
| fifo_not_empty | input | 1 | Live FIFO not-empty level |
| fifo_half_full | input | 1 | Live FIFO half-full level (512 of 1024 words) |
| fifo_ovf_evt | input | 1 | Pulse: FIFO full and another write is arriving |
| about_trig_en | input | 1 | About-trigger mode enabled |
| cdown_tc_evt | input | 1 | Pulse: countdown counter terminal count |
| pacer_irq_en | input | 1 | Pacer terminal-count interrupt enable |
| pacer_tc_evt | input | 1 | Pulse: pacer counter chain terminal count |
| dma_en | input | 1 | DMA transfers enabled |
| dma_tc_evt | input | 1 | Pulse: DMA terminal count |
| fifo_irq_mode | input | 1 | FIFO interrupt source: 0 not-empty, 1 half-full |
| irq_level_code | input | 3 | Interrupt line select / enable code |
| status_q | output | 8 | Status word |
| irq_lines | output | 6 | One-hot pulsed interrupt lines |
| stop_conv | output | 1 | One-cycle request to stop conversions |

## Verification
The interrupt path is exercised four ways: FIFO not-empty edges in the not-empty mode, half-full edges in the half-full mode, FIFO edges while DMA is active, and counter or DMA events under each of the six line codes and one disabled code. Together these show which source is routed to the flag and confirm that the line decode is correct. The flag tests check each event with its enable off and then on. They also write mixed patterns of ones and zeros, and collide an event with a clear, to tell write-zero-to-clear apart from a plain load. A scoreboard queue holds the expected line and width of every pulse. This catches missing, extra and repeated pulses, including a second event while the flag is still set.

// File: rtl/acq_stat_pkg.sv
package acq_stat_pkg;

   localparam int STAT_W      = 8;
   localparam int NUM_FLAGS   = 5;
   localparam int NUM_LINES   = 6;
   localparam int LVL_CODE_W  = 3;

   localparam int BIT_CVEN    = 7;
   localparam int BIT_NE      = 6;
   localparam int BIT_HF      = 5;

   typedef struct packed {
      logic ovf;
      logic cdown;
      logic pacer;
      logic dma;
   } acq_evt_t;

   function automatic logic [NUM_LINES-1:0] level_onehot(input logic [LVL_CODE_W-1:0] code);
      logic [NUM_LINES-1:0] r;
      case (code)
         3'b001:  r = 6'b000001;
         3'b010:  r = 6'b000010;
         3'b011:  r = 6'b000100;
         3'b101:  r = 6'b001000;
         3'b110:  r = 6'b010000;
         3'b111:  r = 6'b100000;
         default: r = 6'b000000;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/acq_event_gate.sv
module acq_event_gate
   import acq_stat_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fifo_enable,
   input  logic                  fifo_not_empty,
   input  logic                  fifo_half_full,
   input  logic                  fifo_ovf_evt,
   input  logic                  about_trig_en,
   input  logic                  cdown_tc_evt,
   input  logic                  pacer_irq_en,
   input  logic                  pacer_tc_evt,
   input  logic                  dma_en,
   input  logic                  dma_tc_evt,
   input  logic                  fifo_irq_mode,
   input  logic [LVL_CODE_W-1:0] irq_level_code,
   output acq_evt_t              evt_set,
   output logic                  int_req
);

   logic ne_prev, hf_prev;
   logic ne_rise, hf_rise, fifo_src, irq_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ne_prev <= 1'b0;
         hf_prev <= 1'b0;
      end else begin
         ne_prev <= fifo_not_empty;
         hf_prev <= fifo_half_full;
      end
   end

   always_comb begin
      ne_rise       = fifo_not_empty & ~ne_prev;
      hf_rise       = fifo_half_full & ~hf_prev;
      evt_set.ovf   = fifo_enable   & fifo_ovf_evt;
      evt_set.cdown = about_trig_en & cdown_tc_evt;
      evt_set.pacer = pacer_irq_en  & pacer_tc_evt;
      evt_set.dma   = dma_en        & dma_tc_evt;
      fifo_src      = dma_en ? 1'b0 : (fifo_irq_mode ? hf_rise : ne_rise);
      irq_on        = (irq_level_code[1:0] != 2'b00);
      int_req       = irq_on & ((evt_set != '0) | fifo_src);
   end

   // R9: with DMA on and no counter/DMA event, FIFO edges never raise a request
   assert_dma_mutes_fifo_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && !fifo_ovf_evt && !cdown_tc_evt && !pacer_tc_evt && !dma_tc_evt) |-> !int_req);

endmodule

// File: rtl/acq_irq_pulser.sv
module acq_irq_pulser
   import acq_stat_pkg::*;
#(
   parameter int PULSE_W = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  int_flag,
   input  logic [LVL_CODE_W-1:0] level_code,
   output logic [NUM_LINES-1:0]  irq_lines
);

   localparam int CW = $clog2(PULSE_W + 1);

   generate
      if (PULSE_W < 1 || PULSE_W > 255) begin : g_bad_width
         $error("acq_irq_pulser: PULSE_W must be 1..255");
      end
   endgenerate

   logic                  flag_d;
   logic                  int_rise;
   logic [CW-1:0]         cnt_q;
   logic [LVL_CODE_W-1:0] code_q;
   logic                  active;

   assign int_rise = int_flag & ~flag_d;
   assign active   = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_d <= 1'b0;
         cnt_q  <= '0;
         code_q <= '0;
      end else begin
         flag_d <= int_flag;
         if (int_rise) begin
            cnt_q  <= CW'(PULSE_W);
            code_q <= level_code;
         end else if (active) begin
            cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   assign irq_lines = active ? level_onehot(code_q) : '0;

   // R12: a flag rise always launches a pulse on the next clock
   assert_pulse_launch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      int_rise |=> active);

   // R11: never more than one line high
   assert_single_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_lines));

endmodule

// File: rtl/acq_status_reg.sv
module acq_status_reg
   import acq_stat_pkg::*;
#(
   parameter int PULSE_W = 4
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   input  logic        fifo_enable,
   input  logic        fifo_not_empty,
   input  logic        fifo_half_full,
   input  logic        fifo_ovf_evt,
   input  logic        about_trig_en,
   input  logic        cdown_tc_evt,
   input  logic        pacer_irq_en,
   input  logic        pacer_tc_evt,
   input  logic        dma_en,
   input  logic        dma_tc_evt,
   input  logic        fifo_irq_mode,
   input  logic [2:0]  irq_level_code,
   output logic [7:0]  status_q,
   output logic [5:0]  irq_lines,
   output logic        stop_conv
);

   acq_evt_t             evt_set;
   logic                 int_req;
   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] flag_q;
   logic                 cven_q;
   logic                 stop_q;
   logic                 unused_wr_bits;

   assign unused_wr_bits = ^wr_data[BIT_NE:BIT_HF];

   acq_event_gate u_gate (
      .clk            (clk),
      .rst_n          (rst_n),
      .fifo_enable    (fifo_enable),
      .fifo_not_empty (fifo_not_empty),
      .fifo_half_full (fifo_half_full),
      .fifo_ovf_evt   (fifo_ovf_evt),
      .about_trig_en  (about_trig_en),
      .cdown_tc_evt   (cdown_tc_evt),
      .pacer_irq_en   (pacer_irq_en),
      .pacer_tc_evt   (pacer_tc_evt),
      .dma_en         (dma_en),
      .dma_tc_evt     (dma_tc_evt),
      .fifo_irq_mode  (fifo_irq_mode),
      .irq_level_code (irq_level_code),
      .evt_set        (evt_set),
      .int_req        (int_req)
   );

   assign set_vec = {evt_set.ovf, evt_set.cdown, evt_set.pacer, evt_set.dma, int_req};

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag_q[gi] <= 1'b0;
            else if (set_vec[gi])
               flag_q[gi] <= 1'b1;
            else if (wr_en && !wr_data[gi])
               flag_q[gi] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cven_q <= 1'b0;
         stop_q <= 1'b0;
      end else begin
         stop_q <= evt_set.ovf;
         if (evt_set.ovf)
            cven_q <= 1'b0;
         else if (wr_en)
            cven_q <= wr_data[BIT_CVEN];
      end
   end

   assign status_q  = {cven_q, fifo_not_empty, fifo_half_full, flag_q};
   assign stop_conv = stop_q;

   acq_irq_pulser #(.PULSE_W(PULSE_W)) u_pulser (
      .clk        (clk),
      .rst_n      (rst_n),
      .int_flag   (flag_q[0]),
      .level_code (irq_level_code),
      .irq_lines  (irq_lines)
   );

   // R3: overflow kills convert enable and requests a stop
   assert_ovf_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_enable && fifo_ovf_evt) |=> (!status_q[7] && status_q[4] && stop_conv));

   // R4: DMA flag cannot appear while DMA is off
   assert_dma_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_en && !status_q[1]) |=> !status_q[1]);

   // R5: write-zero clears countdown flag when no event competes
   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[3] && !(about_trig_en && cdown_tc_evt)) |=> !status_q[3]);

   // R6: event beats a simultaneous clear
   assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[2] && pacer_irq_en && pacer_tc_evt) |=> status_q[2]);

   // R10: interrupt flag stays low under a disabled level code
   assert_int_needs_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level_code[1:0] == 2'b00 && !status_q[0]) |=> !status_q[0]);

endmodule

// File: tb/acq_status_reg_tb.sv
module acq_status_reg_tb;

   localparam int PW = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       fifo_enable, fifo_not_empty, fifo_half_full, fifo_ovf_evt;
   logic       about_trig_en, cdown_tc_evt, pacer_irq_en, pacer_tc_evt;
   logic       dma_en, dma_tc_evt, fifo_irq_mode;
   logic [2:0] irq_level_code;
   logic [7:0] status_q;
   logic [5:0] irq_lines;
   logic       stop_conv;

   int checks = 0;
   int errors = 0;
   int pulses_seen = 0;
   logic [5:0] exp_q[$];

   always #10 clk = ~clk;

   acq_status_reg #(.PULSE_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fifo_enable(fifo_enable), .fifo_not_empty(fifo_not_empty),
      .fifo_half_full(fifo_half_full), .fifo_ovf_evt(fifo_ovf_evt),
      .about_trig_en(about_trig_en), .cdown_tc_evt(cdown_tc_evt),
      .pacer_irq_en(pacer_irq_en), .pacer_tc_evt(pacer_tc_evt),
      .dma_en(dma_en), .dma_tc_evt(dma_tc_evt), .fifo_irq_mode(fifo_irq_mode),
      .irq_level_code(irq_level_code), .status_q(status_q),
      .irq_lines(irq_lines), .stop_conv(stop_conv)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic host_wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic expect_pulse(input int line);
      exp_q.push_back(6'(1) << line);
   endtask

   // monitor: measures each pulse and compares it with the queue head
   logic       in_pulse = 1'b0;
   logic [5:0] cur_line;
   int         cur_w;
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (irq_lines != 6'd0) begin
            if (!in_pulse) begin
               in_pulse = 1'b1; cur_line = irq_lines; cur_w = 1;
            end else begin
               cur_w++;
               if (irq_lines != cur_line) chk("R11 line changed mid-pulse", irq_lines, cur_line);
            end
         end else if (in_pulse) begin
            in_pulse = 1'b0;
            pulses_seen++;
            if (exp_q.size() == 0) begin
               chk("R12 unexpected pulse", cur_line, 0);
            end else begin
               logic [5:0] e;
               e = exp_q.pop_front();
               chk("R11 pulse line", cur_line, e);
               chk("R12 pulse width", cur_w, PW);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
      fifo_enable = 0; fifo_not_empty = 0; fifo_half_full = 0; fifo_ovf_evt = 0;
      about_trig_en = 0; cdown_tc_evt = 0; pacer_irq_en = 0; pacer_tc_evt = 0;
      dma_en = 0; dma_tc_evt = 0; fifo_irq_mode = 0; irq_level_code = 3'b000;
      step(3);
      rst_n = 1'b1;
      step();
      chk("R1 status after reset", status_q, 8'h00);
      chk("R1 irq after reset", irq_lines, 6'h00);
      chk("R1 stop after reset", stop_conv, 1'b0);

      // live FIFO bits
      fifo_not_empty = 1; fifo_half_full = 1; step();
      chk("R2 live bits follow", status_q, 8'h60);
      host_wr(8'h00);
      chk("R2 write zero ignored on live bits", status_q, 8'h60);
      host_wr(8'hFF);
      chk("R7 convert enable written", status_q, 8'hE0);
      fifo_not_empty = 0; fifo_half_full = 0; step();
      chk("R2 live bits drop", status_q, 8'h80);

      // overflow gating and effect
      fifo_ovf_evt = 1; step(); fifo_ovf_evt = 0;
      chk("R4 overflow gated by fifo_enable", status_q, 8'h80);
      chk("R4 no stop when gated", stop_conv, 1'b0);
      fifo_enable = 1; fifo_ovf_evt = 1; step(); fifo_ovf_evt = 0;
      chk("R3 overflow sets flag clears cven", status_q, 8'h10);
      chk("R3 stop pulse", stop_conv, 1'b1);
      step();
      chk("R3 stop one cycle", stop_conv, 1'b0);

      // enables of the other flags
      cdown_tc_evt = 1; step(); cdown_tc_evt = 0;
      chk("R4 countdown gated", status_q, 8'h10);
      about_trig_en = 1; cdown_tc_evt = 1; step(); cdown_tc_evt = 0;
      chk("R4 countdown set", status_q, 8'h18);
      pacer_tc_evt = 1; step(); pacer_tc_evt = 0;
      chk("R4 pacer gated", status_q, 8'h18);
      pacer_irq_en = 1; pacer_tc_evt = 1; step(); pacer_tc_evt = 0;
      chk("R4 pacer set", status_q, 8'h1C);
      dma_tc_evt = 1; step(); dma_tc_evt = 0;
      chk("R4 dma gated", status_q, 8'h1C);
      dma_en = 1; dma_tc_evt = 1; step(); dma_tc_evt = 0;
      chk("R4 dma set", status_q, 8'h1E);

      // write-zero clear
      host_wr(8'h15);
      chk("R5 mixed clear", status_q, 8'h14);
      host_wr(8'h80);
      chk("R5 clear all with cven load", status_q, 8'h80);

      // event wins over clear
      wr_en = 1; wr_data = 8'h00; pacer_tc_evt = 1; step();
      wr_en = 0; pacer_tc_evt = 0;
      chk("R6 event beats clear", status_q, 8'h04);
      host_wr(8'h00);
      chk("R5 clear after collision", status_q, 8'h00);

      // FIFO not-empty interrupt source
      dma_en = 0; fifo_irq_mode = 0; irq_level_code = 3'b001;
      expect_pulse(0);
      fifo_not_empty = 1; step();
      chk("R8 not-empty sets int", status_q, 8'h41);
      step(PW + 3);
      host_wr(8'h00);
      chk("R5 int cleared", status_q, 8'h40);
      fifo_not_empty = 0; step();

      // half-full mode
      fifo_irq_mode = 1; irq_level_code = 3'b010;
      fifo_not_empty = 1; step();
      chk("R8 not-empty ignored in half-full mode", status_q, 8'h40);
      expect_pulse(1);
      fifo_half_full = 1; step();
      chk("R8 half-full sets int", status_q, 8'h61);
      step(PW + 3);
      host_wr(8'h00);
      fifo_not_empty = 0; fifo_half_full = 0; step();
      chk("R5 clean after half-full", status_q, 8'h00);

      // DMA overrides FIFO sources
      dma_en = 1; fifo_irq_mode = 0; irq_level_code = 3'b011;
      fifo_not_empty = 1; fifo_half_full = 1; step();
      chk("R9 fifo edges muted under dma", status_q, 8'h60);
      expect_pulse(2);
      dma_tc_evt = 1; step(); dma_tc_evt = 0;
      chk("R9 dma tc sets int", status_q, 8'h63);
      step(PW + 3);
      host_wr(8'h00);
      fifo_not_empty = 0; fifo_half_full = 0; dma_en = 0; step();
      chk("R9 clean after dma", status_q, 8'h00);

      // disabled code 100
      irq_level_code = 3'b100;
      pacer_tc_evt = 1; step(); pacer_tc_evt = 0;
      chk("R10 code 100 no int", status_q, 8'h04);
      step(PW + 3);
      chk("R10 no line under code 100", irq_lines, 6'h00);
      host_wr(8'h00);

      // upper level codes
      for (int k = 0; k < 3; k++) begin
         irq_level_code = 3'(5 + k);
         expect_pulse(3 + k);
         pacer_tc_evt = 1; step(); pacer_tc_evt = 0;
         chk("R10 enabled code sets int", status_q, 8'h05);
         step(PW + 3);
         host_wr(8'h00);
      end

      // only rising transition pulses
      irq_level_code = 3'b001;
      expect_pulse(0);
      pacer_tc_evt = 1; step(); pacer_tc_evt = 0;
      step(PW + 3);
      pacer_tc_evt = 1; step(); pacer_tc_evt = 0;
      chk("R12 int still set", status_q, 8'h05);
      step(PW + 3);
      chk("R12 pulse count", pulses_seen, 7);
      chk("R12 queue drained", exp_q.size(), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule